// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Selectable Count Source

This block is a 16-bit timer that counts down one step per count event and reloads itself from a base register when it passes zero, emitting a one-cycle underflow pulse each time. The count event comes from a source chosen by a 3-bit field. The choices are every I/O clock, every 8th or every 32nd I/O clock from a free-running prescaler, an underflow pulse from one of three neighbouring timers, or a synchronized rising edge on an input pin. A square-wave style output toggles whenever a count event finds the counter equal to the active compare value.

Software sets up the block through a small register bus. It holds an 8-bit mode word with a run flag, an initialize flag and the source field. It also holds a base value, a compare buffer, and a read-only view of the count. While the initialize flag is set, the counter takes the base value, the output is forced low and the compare buffer moves into the active compare register. Buffered compare writes therefore take effect only at an initialization. Everything runs in the single I/O clock domain.

Top module: `reload_timer16`

## Requirements
- R1: Every register and output is 0 after reset. The mode word at address 0 holds the run flag in bit 7, the initialize flag in bit 6 and the source field in bits 2..0, and these bits are writable. Bits 5..3 (and any bits above 7) always read 0.
- R2: Source 000 gives a count event on every clock. A 5-bit prescaler counts clocks from 0 after reset. Source 001 gives an event when its low 3 bits are all ones, and source 010 gives one when all 5 bits are ones.
- R3: Sources 100, 101 and 110 give a count event in each cycle where cascade input bit 0, 1 or 2 respectively is high.
- R4: Source 111 counts rising edges of the pin through a two-flop synchronizer. The count changes at the third rising clock edge that samples the pin high after it was low.
- R5: Source 011 gives no count event, so the count holds.
- R6: On a count event the counter decrements. If it is 0, it instead reloads the base value, and the underflow output is high for the cycle after that event.
- R7: On a count event where the counter equals the active compare value, the timer output inverts.
- R8: In a cycle where the initialize flag is 1, the next edge loads the base into the counter, clears the timer output and copies the compare buffer into the active compare. Writes to the compare buffer do not change the active compare otherwise.
- R9: With the run flag at 0 the count, output and underflow hold still.
- R10: With run and initialize both 1, initialization happens and no count event is taken.
- R11: Address 1 reads the base, address 2 the compare buffer and address 3 the current count. Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 mode, 1 base, 2 compare buffer, 3 count) |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr, combinational |
| casc_uf | input | 3 | Underflow pulses from three cascade timers |
| pin_in | input | 1 | Asynchronous count pin |
| tmr_out | output | 1 | Timer output |
| uf_pulse | output | 1 | One-cycle underflow pulse |

## Verification
A register write is visible on the read port one edge later. A count event present in a cycle moves the count, the timer output and the underflow pulse at the following edge. A pin edge needs three edges because of the synchronizer and edge detector. The bench keeps a behavioural model that applies exactly these latencies. It compares the model against all outputs and the read data 2 ns after every rising edge, once both have settled. Inputs change only on falling edges, so nothing is sampled while it moves.

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [2:0]   casc_uf,
  input  logic         pin_in,
  output logic         tmr_out,
  output logic         uf_pulse
);

  logic         en, init;
  logic [2:0]   sel;
  logic [W-1:0] base, cbuf, cmp, cnt;
  logic [4:0]   pre;
  logic [2:0]   psync;
  logic         tick;

  wire pin_rise = psync[1] & ~psync[2];
  wire step     = en & ~init & tick;

  always_comb begin
    case (sel)
      3'd0:    tick = 1'b1;
      3'd1:    tick = &pre[2:0];
      3'd2:    tick = &pre;
      3'd4:    tick = casc_uf[0];
      3'd5:    tick = casc_uf[1];
      3'd6:    tick = casc_uf[2];
      3'd7:    tick = pin_rise;
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{(W-8){1'b0}}, en, init, 3'b000, sel};
      2'd1:    bus_rdata = base;
      2'd2:    bus_rdata = cbuf;
      default: bus_rdata = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      init <= 1'b0;
      sel  <= '0;
      base <= '0;
      cbuf <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: {en, init, sel} <= {bus_wdata[7:6], bus_wdata[2:0]};
        2'd1: base <= bus_wdata;
        2'd2: cbuf <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      psync <= '0;
    end else begin
      pre   <= pre + 5'd1;
      psync <= {psync[1:0], pin_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmp      <= '0;
      tmr_out  <= 1'b0;
      uf_pulse <= 1'b0;
    end else begin
      uf_pulse <= 1'b0;
      if (init) begin
        cnt     <= base;
        cmp     <= cbuf;
        tmr_out <= 1'b0;
      end else if (step) begin
        if (cnt == cmp) tmr_out <= ~tmr_out;
        if (cnt == '0) begin
          cnt      <= base;
          uf_pulse <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         init,
  input logic [2:0]   sel,
  input logic [W-1:0] cnt,
  input logic [W-1:0] base,
  input logic [W-1:0] cbuf,
  input logic [W-1:0] cmp,
  input logic         tmr_out,
  input logic         uf_pulse,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_rdata
);

  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd0 |-> bus_rdata[5:3] == 3'b000);

  p_no_prohibited_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd3 && !init) |=> $stable(cnt));

  p_uf_from_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse |-> $past(cnt) == '0);

  p_toggle_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(init) && tmr_out != $past(tmr_out)) |-> $past(cnt) == $past(cmp));

  p_init_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (cnt == $past(base) && cmp == $past(cbuf) && !tmr_out));

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !init) |=> ($stable(cnt) && !uf_pulse));

  p_init_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && init) |=> !uf_pulse);

endmodule

bind reload_timer16 reload_timer16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .init(init), .sel(sel), .cnt(cnt),
  .base(base), .cbuf(cbuf), .cmp(cmp), .tmr_out(tmr_out),
  .uf_pulse(uf_pulse), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_reload_timer16.sv
`timescale 1ns/1ps
module tb_reload_timer16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  casc_uf = '0;
  logic        pin_in = 1'b0;
  logic        tmr_out, uf_pulse;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #5 clk = ~clk;

  reload_timer16 dut (.*);

  // behavioural reference state
  bit        m_en, m_init, m_out, m_uf, s1, s2, s3;
  bit [2:0]  m_sel;
  bit [15:0] m_base, m_buf, m_cmp, m_cnt;
  int        m_cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_init, m_out, m_uf, s1, s2, s3} = '0;
      m_sel = 0; m_base = 0; m_buf = 0; m_cmp = 0; m_cnt = 0; m_cyc = 0;
    end else begin
      bit ev;
      bit [15:0] ncnt, ncmp;
      bit nout, nuf;
      case (m_sel)
        0: ev = 1;
        1: ev = (m_cyc % 8) == 7;
        2: ev = (m_cyc % 32) == 31;
        4: ev = casc_uf[0];
        5: ev = casc_uf[1];
        6: ev = casc_uf[2];
        7: ev = s2 && !s3;
        default: ev = 0;
      endcase
      ncnt = m_cnt; ncmp = m_cmp; nout = m_out; nuf = 0;
      if (m_init) begin
        ncnt = m_base; ncmp = m_buf; nout = 0;
      end else if (m_en && ev) begin
        if (m_cnt == m_cmp) nout = !m_out;
        if (m_cnt == 0) begin ncnt = m_base; nuf = 1; end
        else ncnt = m_cnt - 16'd1;
      end
      s3 = s2; s2 = s1; s1 = pin_in;
      m_cyc = m_cyc + 1;
      if (bus_wr) begin
        if (bus_addr == 0) begin
          m_en = bus_wdata[7]; m_init = bus_wdata[6]; m_sel = bus_wdata[2:0];
        end
        if (bus_addr == 1) m_base = bus_wdata;
        if (bus_addr == 2) m_buf = bus_wdata;
      end
      m_cnt = ncnt; m_cmp = ncmp; m_out = nout; m_uf = nuf;
    end
  end

  function automatic bit [15:0] exp_rd();
    case (bus_addr)
      0: return {8'h00, m_en, m_init, 3'b000, m_sel};
      1: return m_base;
      2: return m_buf;
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(string req, bit [17:0] act, bit [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished)
      chk(cur_req, {uf_pulse, tmr_out, bus_rdata}, {m_uf, m_out, exp_rd()});
  end

  bit rand_on = 1'b0;
  always @(negedge clk) if (rand_on) begin
    casc_uf = 3'($urandom % 8);
    if ($urandom % 3 == 0) pin_in = ~pin_in;
  end

  task automatic wr(bit [1:0] a, bit [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 2'd3;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(bit [2:0] s, int n);
    wr(0, 16'h0040 | s);
    wr(0, 16'h0080 | s);
    idle(n);
  endtask

  initial begin
    #1;
    chk("R1", {uf_pulse, tmr_out, bus_rdata}, 18'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 2'd0;
    @(posedge clk); #2;
    chk("R1", {2'b00, bus_rdata}, 18'd0);
    wr(0, 16'hFFFF);            // run and initialize together
    cur_req = "R10";
    bus_addr = 2'd0;
    @(posedge clk); #2;
    chk("R1", {2'b00, bus_rdata}, 18'h000C7);
    bus_addr = 2'd3;
    idle(6);
    wr(0, 16'h0000);
    cur_req = "R11";
    wr(1, 16'd5); wr(2, 16'd2);
    bus_addr = 2'd1; idle(2); bus_addr = 2'd2; idle(2); bus_addr = 2'd3;
    cur_req = "R2"; start(3'd0, 40);
    cur_req = "R7"; start(3'd1, 120);
    cur_req = "R6"; start(3'd2, 400);
    rand_on = 1'b1;
    cur_req = "R3"; start(3'd4, 80); start(3'd5, 80); start(3'd6, 80);
    cur_req = "R4"; start(3'd7, 200);
    cur_req = "R5"; start(3'd3, 60);
    cur_req = "R9"; wr(0, 16'h0000); idle(40);
    cur_req = "R8"; wr(2, 16'd4); wr(0, 16'h0080); idle(30);
    start(3'd0, 30);
    cur_req = "R10"; wr(0, 16'h00C0); idle(10);
    cur_req = "R6"; wr(1, 16'd0); wr(2, 16'd0); start(3'd0, 20);
    wr(1, 16'hFFFF); start(3'd5, 60);
    rand_on = 1'b0;
    idle(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule